// File: doc/BRIEF.md
# Embedded-Clock Serial Frame Aligner

This block sits behind a serial receiver that already delivers one recovered bit per cycle of a bit-rate clock. The line carries 18-bit frames: a high start bit, sixteen payload bits, and a low stop bit. Because every frame ends in a low and the next one begins with a high, the pair of bits at each frame boundary always forms a rising step. The block uses that step as its framing mark.

While searching, the block checks one candidate bit position per frame. If the rising step is missing there, it moves the candidate one bit later. When the step has been seen at the same position in 150 frames in a row, the block declares lock. It then drives each completed 16-bit payload onto a parallel output once per frame. Before lock the parallel output is released: its enable is low and the data are zero. The active-low lock flag falls in the same cycle in which the first valid word appears.

Lock can be reached from a run of idle zeros followed by frames, which gives a known lock time. It can also be reached from arbitrary frame traffic, which gives no fixed lock time. Once locked, a short burst of bad boundaries is tolerated. A longer burst, or a low reference-ready input, returns the block to the search.

Top module: `deser_frame_lock`

## Requirements
- R1: While `rst` is high, and whenever the block is not locked, `lock_n` is 1, `dout_oe` is 0 and `dout` is 0.
- R2: A frame is 18 bits in this order: start bit (1), payload bits 0 through 15 with the least-significant bit first, then stop bit (0). A boundary is good when the bit at the candidate start position is 1 and the bit just before it is 0.
- R3: Lock is declared on the 150th consecutive good boundary at one alignment. In the cycle after that start bit is sampled, `lock_n` is 0, `dout_oe` is 1, and `dout` holds the payload of the frame that ended just before that start bit. `lock_n` stays 1 on the 149 boundaries before it.
- R4: While searching, a bad boundary clears the qualification count and moves the candidate start position one bit later. Lock then needs 150 new consecutive good boundaries.
- R5: While locked, `dout` changes only at a good boundary, where it takes the payload of the frame that just ended. It holds its value between boundaries.
- R6: While locked, one to three consecutive bad boundaries keep the lock and leave `dout` unchanged. A good boundary resets this run count.
- R7: The fourth consecutive bad boundary drops the lock: `lock_n` becomes 1, `dout_oe` becomes 0, `dout` becomes 0, and the search restarts.
- R8: When `ref_ok` is sampled low, the next cycle shows the unlocked state. The block cannot lock while `ref_ok` stays low.
- R9: Lock is also reached on arbitrary frame data with no idle preamble and at an arbitrary starting bit offset. The first valid word then coincides with the fall of `lock_n` right after a start bit.
- R10: `dout_oe` is always the inverse of `lock_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_ok | input | 1 | Reference clock ready; low forces the unlocked state |
| sdi | input | 1 | Recovered serial data bit |
| dout | output | 16 | Recovered payload word, zero when not enabled |
| dout_oe | output | 1 | Output enable for `dout`; low means released (high impedance) |
| lock_n | output | 1 | Active-low frame lock flag |

## Verification
A wrong bit position shows up within one frame after lock as a rotated or corrupted payload on `dout`. A wrong qualification count moves the fall of `lock_n` off the 150th start bit that follows an idle preamble, so it is seen at that exact boundary. A wrong loss counter makes the lock drop at a different boundary of a burst of frames whose stop bit is wrongly high, or makes the block fail to hold through three such frames. A broken reference-ready path or a broken enable path is seen one cycle after the input changes.

// File: rtl/deser_pkg.sv
package deser_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } link_st_t;
endpackage

// File: rtl/deser_bit_pos.sv
// Bit position inside the frame; a hold repeats position 0 to slip by one bit.
module deser_bit_pos #(
  parameter int FRAME_W = 18
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       hold,
  output logic [$clog2(FRAME_W)-1:0] pos_o,
  output logic                       at_start_o
);
  localparam int POS_W = $clog2(FRAME_W);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_W - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos_q <= '0;
    end else if (!hold) begin
      pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + POS_W'(1);
    end
  end

  assign pos_o      = pos_q;
  assign at_start_o = (pos_q == '0);
endmodule

// File: rtl/deser_word_shift.sv
// Collects payload bits, least-significant first, at positions 1..DATA_W.
module deser_word_shift #(
  parameter int DATA_W  = 16,
  parameter int FRAME_W = DATA_W + 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sdi,
  input  logic [$clog2(FRAME_W)-1:0] pos,
  output logic [DATA_W-1:0]          word_o
);
  localparam int POS_W = $clog2(FRAME_W);
  localparam logic [POS_W-1:0] FIRST_DATA = POS_W'(1);
  localparam logic [POS_W-1:0] LAST_DATA  = POS_W'(DATA_W);

  logic [DATA_W-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
    end else if (pos >= FIRST_DATA && pos <= LAST_DATA) begin
      shift_q <= {sdi, shift_q[DATA_W-1:1]};
    end
  end

  assign word_o = shift_q;
endmodule

// File: rtl/deser_link_fsm.sv
// Search / locked control with the qualification and loss counters.
module deser_link_fsm
  import deser_pkg::*;
#(
  parameter int QUAL_FRAMES = 150,
  parameter int LOSS_LIMIT  = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               ref_ok,
  input  logic                               at_start,
  input  logic                               good,
  output logic                               load,
  output logic                               drop,
  output logic                               slip,
  output logic                               locked,
  output logic [$clog2(QUAL_FRAMES+1)-1:0]   qual_cnt,
  output logic [$clog2(LOSS_LIMIT+1)-1:0]    miss_cnt
);
  localparam int QUAL_W = $clog2(QUAL_FRAMES + 1);
  localparam int LOSS_W = $clog2(LOSS_LIMIT + 1);
  localparam logic [QUAL_W-1:0] QUAL_LAST = QUAL_W'(QUAL_FRAMES - 1);
  localparam logic [LOSS_W-1:0] LOSS_LAST = LOSS_W'(LOSS_LIMIT - 1);

  link_st_t          st_q;
  logic [QUAL_W-1:0] qual_q;
  logic [LOSS_W-1:0] miss_q;
  logic              bad;
  logic              last_miss;

  assign locked    = (st_q == ST_LOCKED);
  assign bad       = at_start && !good;
  assign last_miss = (miss_q == LOSS_LAST);
  assign load      = at_start && good && (locked || qual_q == QUAL_LAST);
  assign drop      = bad && locked && last_miss;
  assign slip      = bad && (!locked || last_miss);

  always_ff @(posedge clk) begin
    if (rst || !ref_ok) begin
      st_q   <= ST_SEARCH;
      qual_q <= '0;
      miss_q <= '0;
    end else if (at_start) begin
      if (!locked) begin
        if (!good) begin
          qual_q <= '0;
        end else if (qual_q == QUAL_LAST) begin
          st_q   <= ST_LOCKED;
          qual_q <= '0;
        end else begin
          qual_q <= qual_q + QUAL_W'(1);
        end
      end else if (good) begin
        miss_q <= '0;
      end else if (last_miss) begin
        st_q   <= ST_SEARCH;
        miss_q <= '0;
      end else begin
        miss_q <= miss_q + LOSS_W'(1);
      end
    end
  end

  assign qual_cnt = qual_q;
  assign miss_cnt = miss_q;
endmodule

// File: rtl/deser_frame_lock.sv
module deser_frame_lock #(
  parameter int DATA_W      = 16,
  parameter int QUAL_FRAMES = 150,
  parameter int LOSS_LIMIT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_ok,
  input  logic              sdi,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              lock_n
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int POS_W   = $clog2(FRAME_W);
  localparam int QUAL_W  = $clog2(QUAL_FRAMES + 1);
  localparam int LOSS_W  = $clog2(LOSS_LIMIT + 1);

  logic              prev_bit;
  logic              at_start;
  logic              good;
  logic              slip;
  logic              load;
  logic              drop;
  logic              locked;
  logic [POS_W-1:0]  pos_q;
  logic [DATA_W-1:0] word;
  logic [QUAL_W-1:0] qual_cnt;
  logic [LOSS_W-1:0] miss_cnt;

  // Previous line bit; reset to 1 so the first bit can never pass as a boundary.
  always_ff @(posedge clk) begin
    if (rst || !ref_ok) prev_bit <= 1'b1;
    else                prev_bit <= sdi;
  end

  assign good = at_start && sdi && !prev_bit;

  deser_bit_pos #(.FRAME_W(FRAME_W)) pos_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (!ref_ok),
    .hold      (slip),
    .pos_o     (pos_q),
    .at_start_o(at_start)
  );

  deser_word_shift #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) shift_i (
    .clk   (clk),
    .rst   (rst),
    .sdi   (sdi),
    .pos   (pos_q),
    .word_o(word)
  );

  deser_link_fsm #(.QUAL_FRAMES(QUAL_FRAMES), .LOSS_LIMIT(LOSS_LIMIT)) fsm_i (
    .clk     (clk),
    .rst     (rst),
    .ref_ok  (ref_ok),
    .at_start(at_start),
    .good    (good),
    .load    (load),
    .drop    (drop),
    .slip    (slip),
    .locked  (locked),
    .qual_cnt(qual_cnt),
    .miss_cnt(miss_cnt)
  );

  // Registered outputs: word, enable and lock flag move on the same edge.
  always_ff @(posedge clk) begin
    if (rst || !ref_ok) begin
      dout    <= '0;
      dout_oe <= 1'b0;
      lock_n  <= 1'b1;
    end else if (load) begin
      dout    <= word;
      dout_oe <= 1'b1;
      lock_n  <= 1'b0;
    end else if (drop) begin
      dout    <= '0;
      dout_oe <= 1'b0;
      lock_n  <= 1'b1;
    end
  end
endmodule

// File: rtl/deser_frame_lock_chk.sv
module deser_frame_lock_chk #(
  parameter int DATA_W      = 16,
  parameter int FRAME_W     = 18,
  parameter int QUAL_FRAMES = 150,
  parameter int LOSS_LIMIT  = 4
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               ref_ok,
  input logic [DATA_W-1:0]                  dout,
  input logic                               dout_oe,
  input logic                               lock_n,
  input logic [$clog2(FRAME_W)-1:0]         pos,
  input logic [$clog2(QUAL_FRAMES+1)-1:0]   qual_cnt,
  input logic [$clog2(LOSS_LIMIT+1)-1:0]    miss_cnt
);
  localparam int POS_W  = $clog2(FRAME_W);
  localparam int QUAL_W = $clog2(QUAL_FRAMES + 1);
  localparam int LOSS_W = $clog2(LOSS_LIMIT + 1);
  localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(FRAME_W - 1);
  localparam logic [QUAL_W-1:0] QUAL_LAST = QUAL_W'(QUAL_FRAMES - 1);
  localparam logic [LOSS_W-1:0] LOSS_LAST = LOSS_W'(LOSS_LIMIT - 1);

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> (dout == '0));

  p_pos_range_r2: assert property (@(posedge clk) disable iff (rst)
    pos <= POS_LAST);

  p_lock_on_qual_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_n) |-> ($past(qual_cnt) == QUAL_LAST && $past(pos) == '0));

  p_word_at_boundary_r5: assert property (@(posedge clk) disable iff (rst)
    (!$stable(dout) && $past(ref_ok)) |-> ($past(pos) == '0));

  p_drop_after_losses_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(lock_n) && $past(ref_ok)) |-> ($past(miss_cnt) == LOSS_LAST));

  p_ref_loss_r8: assert property (@(posedge clk) disable iff (rst)
    !ref_ok |=> (lock_n && !dout_oe));

  p_oe_vs_lock_r10: assert property (@(posedge clk) disable iff (rst)
    dout_oe == !lock_n);
endmodule

bind deser_frame_lock deser_frame_lock_chk #(
  .DATA_W     (DATA_W),
  .FRAME_W    (FRAME_W),
  .QUAL_FRAMES(QUAL_FRAMES),
  .LOSS_LIMIT (LOSS_LIMIT)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .ref_ok  (ref_ok),
  .dout    (dout),
  .dout_oe (dout_oe),
  .lock_n  (lock_n),
  .pos     (pos_q),
  .qual_cnt(qual_cnt),
  .miss_cnt(miss_cnt)
);

// File: tb/deser_frame_lock_tb_top.sv
module deser_frame_lock_tb_top;
  localparam int DW = 16;
  localparam int QF = 150;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_ok = 1'b0;
  logic          sdi = 1'b0;
  logic [DW-1:0] dout;
  logic          dout_oe;
  logic          lock_n;

  always #10 clk = ~clk;

  deser_frame_lock #(.DATA_W(DW), .QUAL_FRAMES(QF), .LOSS_LIMIT(4)) dut_i (
    .clk(clk), .rst(rst), .ref_ok(ref_ok), .sdi(sdi),
    .dout(dout), .dout_oe(dout_oe), .lock_n(lock_n)
  );

  int            checks = 0;
  int            errors = 0;
  int            last_idx = -1;
  int            fall_idx = -1;
  bit            fell = 1'b0;
  logic          prev_lock = 1'b1;
  logic [DW-1:0] fall_dout;
  logic          s_lock, s_oe;
  logic [DW-1:0] s_dout, m_dout, prev_w, hold_w, w;
  bit            flag;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Observe outputs (result of the previous bit), then drive the next bit.
  task automatic put_bit(input logic b, input int idx);
    @(negedge clk);
    if (prev_lock === 1'b1 && lock_n === 1'b0 && !fell) begin
      fell      = 1'b1;
      fall_idx  = last_idx;
      fall_dout = dout;
    end
    prev_lock = lock_n;
    sdi       = b;
    last_idx  = idx;
  endtask

  // R2 frame: start 1, payload LSB first, stop 0 (or 1 when bad_stop).
  task automatic send_frame(input logic [DW-1:0] wd, input bit bad_stop);
    put_bit(1'b1, 0);
    for (int i = 0; i < DW; i++) begin
      put_bit(wd[i], i + 1);
      if (i == 0) begin
        s_lock = lock_n;
        s_oe   = dout_oe;
        s_dout = dout;
      end
      if (i == 8) m_dout = dout;
    end
    put_bit(bad_stop ? 1'b1 : 1'b0, DW + 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put_bit(1'b0, -1);
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return DW'($urandom);
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    chk(lock_n === 1'b1 && dout_oe === 1'b0 && dout === '0, "R1 reset state",
        {15'd0, lock_n, dout}, {15'd1, 16'd0});
    rst = 1'b0;
    ref_ok = 1'b1;

    // R3: idle preamble then exactly 150 frames to lock.
    idle(40);
    flag = 1'b0;
    prev_w = '0;
    for (int k = 1; k < QF; k++) begin
      w = rnd_word();
      send_frame(w, 1'b0);
      if (s_lock !== 1'b1) flag = 1'b1;
      prev_w = w;
    end
    chk(!flag, "R3 no lock before 150th boundary", flag, 0);
    w = rnd_word();
    send_frame(w, 1'b0);
    chk(s_lock === 1'b0, "R3 lock on 150th boundary", s_lock, 0);
    chk(s_dout === prev_w, "R3 first word with lock", s_dout, prev_w);
    chk(s_oe === 1'b1, "R10 enable with lock", s_oe, 1);
    prev_w = w;

    // R2 R5: payload per frame, held mid-frame.
    for (int k = 0; k < 20; k++) begin
      w = rnd_word();
      send_frame(w, 1'b0);
      chk(s_dout === prev_w, "R2 R5 word at boundary", s_dout, prev_w);
      chk(m_dout === s_dout, "R5 word held mid-frame", m_dout, s_dout);
      prev_w = w;
    end
    w = 16'hFFFF;
    send_frame(w, 1'b0);
    chk(s_dout === prev_w, "R2 word at boundary", s_dout, prev_w);
    prev_w = w;
    w = 16'h0001;
    send_frame(w, 1'b0);
    chk(s_dout === 16'hFFFF, "R2 all-ones payload", s_dout, 16'hFFFF);
    prev_w = w;

    // R6: one bad stop bit.
    hold_w = prev_w;
    send_frame(rnd_word(), 1'b1);
    chk(s_dout === hold_w, "R5 load before bad frame", s_dout, hold_w);
    hold_w = s_dout;
    w = rnd_word();
    send_frame(w, 1'b0);
    chk(s_lock === 1'b0, "R6 lock held after one miss", s_lock, 0);
    chk(s_dout === hold_w, "R6 word held on miss", s_dout, hold_w);
    prev_w = w;
    send_frame(rnd_word(), 1'b0);
    chk(s_dout === prev_w, "R6 load after recovery", s_dout, prev_w);

    // R6: three misses, good, three misses, good.
    for (int k = 0; k < 3; k++) send_frame(rnd_word(), 1'b1);
    w = rnd_word();
    send_frame(w, 1'b0);
    chk(s_lock === 1'b0, "R6 lock held after three misses", s_lock, 0);
    for (int k = 0; k < 3; k++) send_frame(rnd_word(), 1'b1);
    prev_w = rnd_word();
    send_frame(prev_w, 1'b0);
    chk(s_lock === 1'b0, "R6 miss run reset by good boundary", s_lock, 0);
    send_frame(rnd_word(), 1'b0);
    chk(s_dout === prev_w, "R6 load after second run", s_dout, prev_w);

    // R7: four misses drop the lock.
    for (int k = 0; k < 3; k++) send_frame(rnd_word(), 1'b1);
    send_frame(rnd_word(), 1'b1);
    chk(s_lock === 1'b0, "R7 still locked after third miss", s_lock, 0);
    send_frame(rnd_word(), 1'b0);
    chk(s_lock === 1'b1 && s_oe === 1'b0, "R7 lock dropped on fourth miss",
        {s_lock, s_oe}, 2'b10);
    chk(s_dout === '0, "R7 output cleared", s_dout, 0);

    // R4: partial qualification is discarded.
    idle(40);
    for (int k = 0; k < 100; k++) send_frame(rnd_word(), 1'b0);
    idle(40);
    flag = 1'b0;
    for (int k = 1; k < QF; k++) begin
      w = rnd_word();
      send_frame(w, 1'b0);
      if (s_lock !== 1'b1) flag = 1'b1;
      prev_w = w;
    end
    chk(!flag, "R4 count restarted after miss", flag, 0);
    w = rnd_word();
    send_frame(w, 1'b0);
    chk(s_lock === 1'b0 && s_dout === prev_w, "R4 lock after 150 new boundaries",
        s_dout, prev_w);

    // R8: reference loss.
    ref_ok = 1'b0;
    send_frame(rnd_word(), 1'b0);
    chk(s_lock === 1'b1 && s_oe === 1'b0, "R8 unlock on ref loss", {s_lock, s_oe}, 2'b10);
    flag = 1'b0;
    for (int k = 0; k < 160; k++) begin
      send_frame(rnd_word(), 1'b0);
      if (s_lock !== 1'b1 || s_oe !== 1'b0 || s_dout !== '0) flag = 1'b1;
    end
    chk(!flag, "R8 no lock while ref low", flag, 0);
    chk(s_dout === '0, "R1 output zero while unlocked", s_dout, 0);

    // R9: random data, odd bit offset, no preamble.
    ref_ok = 1'b1;
    fell = 1'b0;
    for (int i = 0; i < 7; i++) put_bit(logic'($urandom_range(1, 0)), -1);
    prev_w = '0;
    for (int k = 0; k < 400 && !fell; k++) begin
      w = rnd_word();
      send_frame(w, 1'b0);
      if (fell) begin
        chk(fall_idx == 0, "R9 lock right after a start bit", fall_idx, 0);
        chk(fall_dout === prev_w, "R9 first word on random data", fall_dout, prev_w);
      end
      prev_w = w;
    end
    chk(fell, "R9 lock reached on random data", fell, 1);
    send_frame(rnd_word(), 1'b0);
    chk(s_dout === prev_w, "R5 word after random lock", s_dout, prev_w);
    chk(s_oe === !s_lock, "R10 enable vs lock", s_oe, !s_lock);

    summary();
    $finish;
  end
endmodule